// File: doc/BRIEF.md
# Write-Only Two-Wire Control Slave

This block is the configuration port of an audio amplifier. A host on a two-wire I2C bus sends an address byte and then any number of one-byte register commands, and this block turns them into byte strobes for a register bank. It does not drive SCL. On SDA it only pulls low, through an open-drain output, to acknowledge. Both bus lines are sampled by the system clock, so SCL has to be much slower than that clock.

A transaction opens with START. The first byte is the device address. The block answers one of two addresses, and an address-select pin picks which one. After a matching address with the write direction, every following byte is a complete command on its own. Each such byte gets an acknowledge and a single-cycle strobe. A wrong address, or the read direction, parks the block until the next START. The block has no read path, no clock stretching, no 10-bit addressing and no general call.

Top module: `ctl_i2c_wr_slave`

## Requirements
- R1: After synchronous reset, `sda_pull` and `cmd_valid` are both 0.
- R2: The address byte is received MSB first on SCL rising edges. It matches when it equals binary 1111_10S0, with S the level of `addr_sel`: 0xF8 when `addr_sel`=0 and 0xFA when `addr_sel`=1. On a match, `sda_pull` is 1 throughout the high phase of the ninth SCL clock.
- R3: An address byte that differs in any of bits 7..1 is not acknowledged. Bytes clocked after it, before the next START, give neither an acknowledge nor a strobe.
- R4: An address byte with bit 0 (R/W) set to 1 is not acknowledged. Later bytes are ignored until the next START.
- R5: Each data byte is assembled MSB first and presented on `cmd_byte` with `cmd_valid`=1. The strobe appears after the eighth rising SCL edge of that byte, while SCL is still high. The byte is then acknowledged on the ninth clock.
- R6: Any number of data bytes may follow one address. Each produces its own strobe and its own acknowledge, in bus order.
- R7: The address byte never produces a strobe.
- R8: A START (SDA falling while SCL is high) seen in any state, including the middle of a byte, restarts address reception from bit 7.
- R9: A STOP (SDA rising while SCL is high) returns the block to idle. Bytes clocked afterwards without a new START are ignored: no acknowledge and no strobe.
- R10: `sda_pull` changes only while the synchronized SCL is low. The acknowledge is released after the falling SCL edge that ends the ninth clock.
- R11: `cmd_valid` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Selects between the two device addresses |
| sda_pull | output | 1 | 1 drives SDA low (open drain); 0 releases it |
| cmd_valid | output | 1 | One-cycle strobe for a received command byte |
| cmd_byte | output | 8 | Command byte, valid while `cmd_valid` is 1 |

## Verification
The bench flips bit 1 of the address against `addr_sel`, sets the R/W bit, and clocks bytes after a STOP with no new START. A design that decodes too little of the address, ignores direction or fails to go idle would acknowledge these or emit strobes. It also aborts an address in mid-byte with a repeated START. A bit counter that is not cleared would misalign the next byte and strobe the wrong value. Random multi-byte transactions check that each byte is strobed once, with its bits in order. A stale strobe, an extra strobe or an acknowledge held past the ninth falling edge would each break the check on strobe count or the check on release.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_SETUP,
        ST_ACK_DRIVE,
        ST_DATA
    } slv_state_e;

    // Synchronized bus levels and the events derived from them
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Device address: upper five bits fixed, then 0, select level, write bit 0
    function automatic logic [BYTE_W-1:0] dev_addr(input logic [4:0] hi, input logic sel);
        return {hi, 1'b0, sel, 1'b0};
    endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync
    import i2cw_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw = {scl_in, sda_in};

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    always_comb begin
        ev.scl      = synced[1];
        ev.sda      = synced[0];
        ev.scl_rise = synced[1] & ~prev[1];
        ev.scl_fall = ~synced[1] & prev[1];
        ev.start    = synced[1] & prev[1] & prev[0] & ~synced[0];
        ev.stop     = synced[1] & prev[1] & ~prev[0] & synced[0];
    end

endmodule

// File: rtl/i2cw_bytein.sv
module i2cw_bytein
    import i2cw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              sample,
    input  logic              bit_in,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val
);
    logic [BIT_CNT_W-1:0] cnt;
    logic [BYTE_W-2:0]    shreg;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt   <= '0;
            shreg <= '0;
        end else if (sample) begin
            cnt   <= cnt + 1'b1;
            shreg <= {shreg[BYTE_W-3:0], bit_in};
        end
    end

    assign byte_done = sample && (cnt == BIT_CNT_W'(BYTE_W - 1));
    assign byte_val  = {shreg, bit_in};

endmodule

// File: rtl/ctl_i2c_wr_slave.sv
module ctl_i2c_wr_slave
    import i2cw_pkg::*;
#(
    parameter logic [4:0] ADDR_HI     = 5'b11111,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              addr_sel,
    output logic              sda_pull,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_byte
);
    bus_ev_t           ev;
    slv_state_e        state;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_val;
    logic              shift_clr;
    logic              shift_en;

    i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    assign shift_clr = ev.start || (state == ST_ACK_DRIVE && ev.scl_fall);
    assign shift_en  = ev.scl_rise && !ev.start && !ev.stop &&
                       (state == ST_ADDR || state == ST_DATA);

    i2cw_bytein u_bytein (
        .clk       (clk),
        .rst       (rst),
        .clr       (shift_clr),
        .sample    (shift_en),
        .bit_in    (ev.sda),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            sda_pull  <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            if (ev.start) begin
                state    <= ST_ADDR;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR: if (byte_done) begin
                        if (byte_val == dev_addr(ADDR_HI, addr_sel)) state <= ST_ACK_SETUP;
                        else                                          state <= ST_IDLE;
                    end
                    ST_DATA: if (byte_done) begin
                        cmd_valid <= 1'b1;
                        cmd_byte  <= byte_val;
                        state     <= ST_ACK_SETUP;
                    end
                    ST_ACK_SETUP: if (ev.scl_fall) begin
                        sda_pull <= 1'b1;
                        state    <= ST_ACK_DRIVE;
                    end
                    ST_ACK_DRIVE: if (ev.scl_fall) begin
                        sda_pull <= 1'b0;
                        state    <= ST_DATA;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assert_strobe_single_R11: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    assert_strobe_scl_high_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> ev.scl);

    assert_pull_rise_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !ev.scl);

    assert_pull_fall_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull) |-> !ev.scl);

    assert_idle_released_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_pull);

endmodule

// File: tb/ctl_i2c_wr_slave_test.sv
module ctl_i2c_wr_slave_test;

    localparam int Q = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       addr_sel = 1'b0;
    logic       sda_pull;
    logic       cmd_valid;
    logic [7:0] cmd_byte;
    logic       sda_line;

    int checks = 0;
    int fails = 0;

    logic [7:0] seen [256];
    int         seen_n = 0;

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    ctl_i2c_wr_slave uut (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (m_scl),
        .sda_in    (sda_line),
        .addr_sel  (addr_sel),
        .sda_pull  (sda_pull),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte)
    );

    always @(posedge clk) begin
        if (!rst && cmd_valid && seen_n < 256) begin
            seen[seen_n] = cmd_byte;
            seen_n = seen_n + 1;
        end
    end

    function automatic logic [7:0] exp_addr(input logic sel);
        return {5'b11111, 1'b0, sel, 1'b0};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_scl = 1'b0; wq(Q);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        m_scl = 1'b0; wq(Q);
        m_sda = 1'b0; wq(Q);
        m_scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_scl = 1'b0; wq(Q);
            m_sda = b[i]; wq(Q);
            m_scl = 1'b1; wq(2 * Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ackd, output bit relsd);
        send_bits(b, 8);
        m_scl = 1'b0; wq(Q);
        m_sda = 1'b1; wq(Q);
        m_scl = 1'b1; wq(Q);
        ackd = sda_pull;
        wq(Q);
        m_scl = 1'b0; wq(Q);
        relsd = !sda_pull;
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        bit a, r;
        int base;
        logic [7:0] exp_q [8];
        void'($urandom(32'd4242));

        wq(10);
        // R1: reset state
        check(sda_pull == 1'b0, "R1 sda_pull", sda_pull, 0);
        check(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
        rst = 1'b0;
        wq(10);

        // R2, R5, R7: sel=0, one byte
        addr_sel = 1'b0;
        base = seen_n;
        i2c_start();
        send_byte(8'hF8, a, r);
        check(a, "R2 ack 0xF8", a, 1);
        check(r, "R10 release after addr ack", r, 1);
        check(seen_n == base, "R7 no strobe on address", seen_n - base, 0);
        send_byte(8'h5C, a, r);
        check(a, "R5 data ack", a, 1);
        check(r, "R10 release after data ack", r, 1);
        i2c_stop();
        check(seen_n == base + 1, "R5 strobe count", seen_n - base, 1);
        check(seen[base] == 8'h5C, "R5 byte value", seen[base], 8'h5C);

        // R2: sel=1 answers 0xFA, not 0xF8
        addr_sel = 1'b1;
        base = seen_n;
        i2c_start();
        send_byte(8'hF8, a, r);
        check(!a, "R3 0xF8 nack when sel=1", a, 0);
        send_byte(8'h11, a, r);
        check(!a, "R3 later byte nack", a, 0);
        i2c_stop();
        check(seen_n == base, "R3 no strobe after mismatch", seen_n - base, 0);
        i2c_start();
        send_byte(8'hFA, a, r);
        check(a, "R2 ack 0xFA", a, 1);
        send_byte(8'hA3, a, r);
        i2c_stop();
        check(seen_n == base + 1 && seen[base] == 8'hA3, "R2 byte after 0xFA", seen[base], 8'hA3);

        // R3: upper bits wrong
        addr_sel = 1'b0;
        base = seen_n;
        i2c_start();
        send_byte(8'h78, a, r);
        check(!a, "R3 0x78 nack", a, 0);
        i2c_stop();

        // R4: read direction
        i2c_start();
        send_byte(8'hF9, a, r);
        check(!a, "R4 read nack", a, 0);
        send_byte(8'h33, a, r);
        check(!a, "R4 following byte nack", a, 0);
        i2c_stop();
        check(seen_n == base, "R4 no strobe", seen_n - base, 0);

        // R9: bytes after STOP without START
        i2c_start();
        send_byte(8'hF8, a, r);
        i2c_stop();
        send_byte(8'h66, a, r);
        check(!a, "R9 no ack after stop", a, 0);
        check(seen_n == base, "R9 no strobe after stop", seen_n - base, 0);

        // R8: restart in the middle of the address byte
        i2c_start();
        send_bits(8'hF8, 3);
        i2c_start();
        send_byte(8'hF8, a, r);
        check(a, "R8 ack after restart", a, 1);
        send_byte(8'h0F, a, r);
        i2c_stop();
        check(seen_n == base + 1 && seen[base] == 8'h0F, "R8 byte after restart", seen[base], 8'h0F);

        // R6: random multi-byte transactions
        for (int t = 0; t < 10; t++) begin
            int nb;
            bit all_ack;
            addr_sel = 1'($urandom);
            nb = 1 + int'($urandom % 5);
            base = seen_n;
            all_ack = 1'b1;
            i2c_start();
            send_byte(exp_addr(addr_sel), a, r);
            check(a, "R2 random addr ack", a, 1);
            for (int k = 0; k < nb; k++) begin
                exp_q[k] = 8'($urandom);
                send_byte(exp_q[k], a, r);
                all_ack &= a & r;
            end
            i2c_stop();
            check(all_ack, "R6 every byte acked and released", all_ack, 1);
            check(seen_n - base == nb, "R6 strobe count", seen_n - base, nb);
            for (int k = 0; k < nb; k++)
                check(seen[base + k] == exp_q[k], "R6 byte order/value", seen[base + k], exp_q[k]);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule